// File: doc/BRIEF.md
# Converter Ready and Calibration Sequencer

This block sequences the digital side of a two-channel sigma-delta converter. It runs on the converter's master input clock. A programmable output-data period, counted in input clocks, sets the rate at which results are due. The block drives the active-low data-ready flag, the reset of the filter and modulator, and a load strobe for the data register. It also drives a per-channel load strobe for each offset coefficient register and each gain coefficient register. The analog path and the arithmetic are outside the block; the strobes mark when they would act.

A sync input gates all activity. While it is high, the filter and modulator stay in reset. When it is sampled low after being high, the operation chosen by the two mode bits starts. A setup write carries the two mode bits and a channel select. When such a write picks a calibration while sync is already low, that calibration starts at once. Calibrations clear the mode bits when they finish. They then deliver their first result after a fixed pipeline delay.

The start edge is the first rising clock edge at which a sync high-to-low change or a qualifying setup write is sampled. All delays below count rising edges after the start edge.

Top module: `sd_ready_seq`

## Requirements
- R1: After reset, `drdy_n` is 1, `mode_q` is 00, `mod_rst` is 1, and `data_ld`, `ofs_ld` and `gain_ld` are all 0.
- R2: While sync is high, `mod_rst` is 1 and no data or coefficient load strobe fires. Sync sampled low after being high starts the operation selected by `mode_q`.
- R3: With mode 00, `drdy_n` goes low 3·P edges after the start edge, where P is `odr_period`. `data_ld` pulses for one cycle in that same cycle.
- R4: While sync stays low in mode 00, a new result is due every P edges after the first. Each result pulses `data_ld` and drives `drdy_n` low.
- R5: `rd_done` sampled while `drdy_n` is low drives `drdy_n` high on the next edge.
- R6: If the current result has not been read, `drdy_n` rises P−HOLD_CLKS edges after it fell. It stays high for HOLD_CLKS cycles, then goes low with the next result.
- R7: If sync rises while `drdy_n` is low, `drdy_n` stays low until `rd_done` is seen. A later start edge drives `drdy_n` high.
- R8: Mode 01 (self-calibration) clears `mode_q` to 00 at 6·P edges. It pulses the offset strobe at 3·P and the gain strobe at 6·P. It drives `drdy_n` low at 9·P + PIPE_CLKS edges.
- R9: Mode 10 (zero-scale system calibration) and mode 11 (full-scale system calibration) clear `mode_q` at 3·P edges. They drive `drdy_n` low at 4·P + PIPE_CLKS edges. Mode 10 pulses only the offset strobe and mode 11 only the gain strobe, both at 3·P.
- R10: A setup write with a nonzero mode while sync is low starts that calibration. The write edge is the start edge, and the timing matches a sync-started calibration.
- R11: Coefficient strobes fire only on the bit of `ofs_ld`/`gain_ld` indexed by the channel selected at the start edge. Bit 0 is channel 0 and bit 1 is channel 1.
- R12: A setup write while a calibration's period count is in progress and sync is low aborts that calibration. The write edge is the new start edge.
- R13: A setup write makes `mode_q` equal to the written mode bits on the next edge, whatever the sync level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| odr_period | input | PW | Output-data period in input clocks (must exceed HOLD_CLKS) |
| sync_in | input | 1 | High holds the converter stopped; high-to-low starts an operation |
| setup_wr | input | 1 | Setup write strobe |
| setup_mode | input | 2 | Mode bits carried by the write: 00 normal, 01 self, 10 zero-scale, 11 full-scale |
| setup_ch | input | CHW | Channel select carried by the write |
| rd_done | input | 1 | Marks completion of a data-register read |
| drdy_n | output | 1 | Active-low data-ready |
| mode_q | output | 2 | Mode-bit readback |
| mod_rst | output | 1 | Filter and modulator reset |
| data_ld | output | 1 | Data-register load strobe |
| ofs_ld | output | CH | Offset-register load strobe, one bit per channel |
| gain_ld | output | CH | Gain-register load strobe, one bit per channel |

## Verification
The properties assume `odr_period` stays constant and above HOLD_CLKS while sync is low. They also assume `rd_done` and `setup_wr` are single-cycle pulses driven between clock edges. The stimulus changes the period only while sync is high, which in practice means it never changes, since a single value of 600 is used throughout. Writes and reads are issued from the falling clock edge for exactly one cycle, and sync changes only at the falling edge.

// File: rtl/sd_ready_seq.sv
module sd_ready_seq #(
  parameter int PW        = 16,
  parameter int CH        = 2,
  parameter int PIPE_CLKS = 2000,
  parameter int HOLD_CLKS = 500,
  localparam int CHW = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PW-1:0]  odr_period,
  input  logic           sync_in,
  input  logic           setup_wr,
  input  logic [1:0]     setup_mode,
  input  logic [CHW-1:0] setup_ch,
  input  logic           rd_done,
  output logic           drdy_n,
  output logic [1:0]     mode_q,
  output logic           mod_rst,
  output logic           data_ld,
  output logic [CH-1:0]  ofs_ld,
  output logic [CH-1:0]  gain_ld
);

  localparam int PIW = $clog2(PIPE_CLKS + 1);
  localparam int CW  = (PW > PIW) ? PW : PIW;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PIPE, S_RUN} st_t;

  st_t            st;
  logic           sync_d;
  logic [CW-1:0]  cyc;
  logic [3:0]     nper;
  logic [1:0]     op;
  logic [CHW-1:0] ch_q, cal_ch;

  logic [1:0]     mode_nxt;
  logic [CHW-1:0] ch_nxt;
  logic           sync_fall, cal_busy, wr_start, start;
  logic [CW-1:0]  per_last, hold_pt, pipe_last;
  logic [3:0]     nper_nxt, rdy_at, clr_at;
  logic           do_ofs, do_gain;

  assign mode_nxt  = setup_wr ? setup_mode : mode_q;
  assign ch_nxt    = setup_wr ? setup_ch : ch_q;
  assign sync_fall = sync_d & ~sync_in;
  assign cal_busy  = (st == S_WAIT) && (op != 2'b00);
  assign wr_start  = setup_wr & ~sync_in & ~sync_d & ((setup_mode != 2'b00) | cal_busy);
  assign start     = sync_fall | wr_start;

  assign per_last  = CW'(odr_period) - CW'(1);
  assign hold_pt   = CW'(odr_period) - CW'(HOLD_CLKS) - CW'(1);
  assign pipe_last = CW'(PIPE_CLKS - 1);
  assign nper_nxt  = nper + 4'd1;

  assign rdy_at  = (op == 2'b00) ? 4'd3 : (op == 2'b01) ? 4'd9 : 4'd4;
  assign clr_at  = (op == 2'b01) ? 4'd6 : 4'd3;
  assign do_ofs  = ((op == 2'b01) || (op == 2'b10)) && (nper_nxt == 4'd3);
  assign do_gain = ((op == 2'b01) && (nper_nxt == 4'd6)) ||
                   ((op == 2'b11) && (nper_nxt == 4'd3));

  assign mod_rst = sync_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sync_d  <= 1'b1;
      cyc     <= '0;
      nper    <= '0;
      op      <= 2'b00;
      cal_ch  <= '0;
      ch_q    <= '0;
      mode_q  <= 2'b00;
      drdy_n  <= 1'b1;
      data_ld <= 1'b0;
      ofs_ld  <= '0;
      gain_ld <= '0;
    end else begin
      sync_d  <= sync_in;
      data_ld <= 1'b0;
      ofs_ld  <= '0;
      gain_ld <= '0;

      if (sync_in) begin
        st   <= S_IDLE;
        cyc  <= '0;
        nper <= '0;
        if (rd_done) drdy_n <= 1'b1;
      end else if (start) begin
        st     <= S_WAIT;
        cyc    <= '0;
        nper   <= '0;
        op     <= mode_nxt;
        cal_ch <= ch_nxt;
        drdy_n <= 1'b1;
      end else begin
        if (rd_done) drdy_n <= 1'b1;
        case (st)
          S_WAIT: begin
            if (cyc == per_last) begin
              cyc  <= '0;
              nper <= nper_nxt;
              if (do_ofs)  ofs_ld[cal_ch]  <= 1'b1;
              if (do_gain) gain_ld[cal_ch] <= 1'b1;
              if (op != 2'b00 && nper_nxt == clr_at) mode_q <= 2'b00;
              if (nper_nxt == rdy_at) begin
                if (op == 2'b00) begin
                  st      <= S_RUN;
                  drdy_n  <= 1'b0;
                  data_ld <= 1'b1;
                end else begin
                  st <= S_PIPE;
                end
              end
            end else begin
              cyc <= cyc + CW'(1);
            end
          end
          S_PIPE: begin
            if (cyc == pipe_last) begin
              cyc     <= '0;
              st      <= S_RUN;
              drdy_n  <= 1'b0;
              data_ld <= 1'b1;
            end else begin
              cyc <= cyc + CW'(1);
            end
          end
          S_RUN: begin
            if (cyc == per_last) begin
              cyc     <= '0;
              drdy_n  <= 1'b0;
              data_ld <= 1'b1;
            end else begin
              cyc <= cyc + CW'(1);
              if (cyc == hold_pt) drdy_n <= 1'b1;
            end
          end
          default: ;
        endcase
      end

      if (setup_wr) begin
        mode_q <= setup_mode;
        ch_q   <= setup_ch;
      end
    end
  end

endmodule

// File: rtl/sd_ready_seq_chk.sv
module sd_ready_seq_chk #(
  parameter int CH = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_in,
  input logic          setup_wr,
  input logic [1:0]    setup_mode,
  input logic          rd_done,
  input logic          drdy_n,
  input logic [1:0]    mode_q,
  input logic          mod_rst,
  input logic          data_ld,
  input logic [CH-1:0] ofs_ld,
  input logic [CH-1:0] gain_ld
);

  assert_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst |-> (!data_ld && ofs_ld == '0 && gain_ld == '0));

  assert_load_flags_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_ld |-> !drdy_n);

  assert_fall_needs_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> data_ld);

  assert_ready_held_in_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_rst && sync_in && !drdy_n && !rd_done) |=> !drdy_n);

  assert_read_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!drdy_n && rd_done && !data_ld && !mod_rst && !sync_in) |=> (drdy_n || data_ld));

  assert_gain_ends_cal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|gain_ld) |-> (mode_q == 2'b00));

  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ofs_ld, gain_ld}));

  assert_mode_written_R13: assert property (@(posedge clk) disable iff (!rst_n)
    setup_wr |=> (mode_q == $past(setup_mode)));

endmodule

bind sd_ready_seq sd_ready_seq_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .setup_wr(setup_wr),
  .setup_mode(setup_mode), .rd_done(rd_done), .drdy_n(drdy_n), .mode_q(mode_q),
  .mod_rst(mod_rst), .data_ld(data_ld), .ofs_ld(ofs_ld), .gain_ld(gain_ld)
);

// File: tb/sd_ready_seq_bench.sv
module sd_ready_seq_bench;
  localparam int P    = 600;
  localparam int PIPE = 2000;
  localparam int HOLD = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] odr_period = 16'(P);
  logic sync_in = 1'b1, setup_wr = 1'b0, rd_done = 1'b0;
  logic [1:0] setup_mode = 2'b00;
  logic [0:0] setup_ch = 1'b0;
  logic drdy_n, mod_rst, data_ld;
  logic [1:0] mode_q, ofs_ld, gain_ld;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sd_ready_seq u_sd_ready_seq (
    .clk(clk), .rst_n(rst_n), .odr_period(odr_period), .sync_in(sync_in),
    .setup_wr(setup_wr), .setup_mode(setup_mode), .setup_ch(setup_ch),
    .rd_done(rd_done), .drdy_n(drdy_n), .mode_q(mode_q), .mod_rst(mod_rst),
    .data_ld(data_ld), .ofs_ld(ofs_ld), .gain_ld(gain_ld)
  );

  typedef struct packed {
    logic [1:0] md;
    logic       ch;
    int         clr;
    int         rdy;
    int         ofs_t;
    logic [1:0] ofs;
    logic [1:0] gn;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{2'b00, 1'b0, 1,   3*P,        0,   2'b00, 2'b00},
    '{2'b01, 1'b0, 6*P, 9*P + PIPE, 3*P, 2'b01, 2'b01},
    '{2'b01, 1'b1, 6*P, 9*P + PIPE, 3*P, 2'b10, 2'b10},
    '{2'b10, 1'b1, 3*P, 4*P + PIPE, 3*P, 2'b10, 2'b00},
    '{2'b11, 1'b0, 3*P, 4*P + PIPE, 0,   2'b00, 2'b01}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic write_setup(input logic [1:0] md, input logic ch);
    @(negedge clk);
    setup_wr = 1'b1; setup_mode = md; setup_ch = ch;
  endtask

  // Start edge is the next posedge; counts edges after it until drdy_n falls.
  task automatic measure(output int t_rdy, output int t_clr, output int t_ofs,
                         output logic [1:0] ofs_seen, output logic [1:0] gn_seen);
    int n;
    t_rdy = -1; t_clr = 0; t_ofs = 0; ofs_seen = 0; gn_seen = 0;
    @(posedge clk);
    #1 setup_wr = 1'b0;
    n = 0;
    while (n < 20000 && t_rdy < 0) begin
      @(posedge clk); #1;
      n++;
      if (t_clr == 0 && mode_q == 2'b00) t_clr = n;
      if (t_ofs == 0 && |ofs_ld) t_ofs = n;
      ofs_seen |= ofs_ld;
      gn_seen  |= gain_ld;
      if (!drdy_n) t_rdy = n;
    end
  endtask

  task automatic count_until(input logic lvl, output int n, output bit ld);
    n = 0; ld = 0;
    do begin
      @(posedge clk); #1;
      n++;
      ld = data_ld;
    end while (drdy_n != lvl && n < 5000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int tr, tc, to, n;
    logic [1:0] os, gs;
    bit ld, any_ld;

    repeat (3) @(posedge clk);
    #1;
    chk(drdy_n === 1'b1, "R1 drdy_n", drdy_n, 1);
    chk(mode_q === 2'b00, "R1 mode_q", mode_q, 0);
    chk(mod_rst === 1'b1, "R1 mod_rst", mod_rst, 1);
    chk({data_ld, ofs_ld, gain_ld} === 5'b0, "R1 strobes", {data_ld, ofs_ld, gain_ld}, 0);
    @(negedge clk) rst_n = 1'b1;

    foreach (VEC[i]) begin
      @(negedge clk) sync_in = 1'b1;
      write_setup(VEC[i].md, VEC[i].ch);
      @(negedge clk) setup_wr = 1'b0;
      chk(mode_q == VEC[i].md, "R13 mode readback", mode_q, VEC[i].md);
      chk(mod_rst && !data_ld, "R2 held in reset", mod_rst, 1);
      sync_in = 1'b0;
      measure(tr, tc, to, os, gs);
      chk(tr == VEC[i].rdy, "R3/R8/R9 ready delay", tr, VEC[i].rdy);
      chk(data_ld == 1'b1, "R3 data load with ready", data_ld, 1);
      chk(tc == VEC[i].clr, "R8/R9 mode clear delay", tc, VEC[i].clr);
      chk(to == VEC[i].ofs_t, "R8/R9 offset strobe time", to, VEC[i].ofs_t);
      chk(os == VEC[i].ofs, "R11 offset strobe channel", os, VEC[i].ofs);
      chk(gs == VEC[i].gn, "R11 gain strobe channel", gs, VEC[i].gn);
    end

    // Free-running mode 00: read, period, unread hold window
    @(negedge clk) sync_in = 1'b1;
    write_setup(2'b00, 1'b0);
    @(negedge clk) setup_wr = 1'b0; sync_in = 1'b0;
    measure(tr, tc, to, os, gs);
    @(negedge clk) rd_done = 1'b1;
    @(posedge clk); #1;
    chk(drdy_n == 1'b1, "R5 read releases ready", drdy_n, 1);
    @(negedge clk) rd_done = 1'b0;
    count_until(1'b0, n, ld);
    chk(n + 1 == P, "R4 result period", n + 1, P);
    chk(ld, "R4 data load each period", ld, 1);
    count_until(1'b1, n, ld);
    chk(n == P - HOLD, "R6 unread rise point", n, P - HOLD);
    count_until(1'b0, n, ld);
    chk(n == HOLD, "R6 high window", n, HOLD);
    chk(ld, "R6 new result flagged", ld, 1);

    // Sync rises with unread data
    @(negedge clk) sync_in = 1'b1;
    any_ld = 0;
    for (int k = 0; k < 2*P; k++) begin
      @(posedge clk); #1;
      any_ld |= data_ld;
    end
    chk(drdy_n == 1'b0, "R7 ready held low in sync", drdy_n, 0);
    chk(!any_ld, "R2 no result while sync high", any_ld, 0);
    @(negedge clk) rd_done = 1'b1;
    @(posedge clk); #1;
    chk(drdy_n == 1'b1, "R7 read releases in sync", drdy_n, 1);
    @(negedge clk) rd_done = 1'b0; sync_in = 1'b0;
    measure(tr, tc, to, os, gs);
    @(negedge clk) sync_in = 1'b1;
    repeat (10) @(negedge clk);
    chk(drdy_n == 1'b0, "R7 still low", drdy_n, 0);
    sync_in = 1'b0;
    @(posedge clk); #1;
    chk(drdy_n == 1'b1, "R7 new start releases", drdy_n, 1);

    // Calibration started by a write while running
    repeat (50) @(negedge clk);
    setup_wr = 1'b1; setup_mode = 2'b10; setup_ch = 1'b0;
    measure(tr, tc, to, os, gs);
    chk(tr == 4*P + PIPE, "R10 ready delay", tr, 4*P + PIPE);
    chk(tc == 3*P, "R10 mode clear", tc, 3*P);
    chk(os == 2'b01 && gs == 2'b00, "R10 offset only ch0", {os, gs}, 4'b0100);

    // Abort a self-calibration with a new write
    @(negedge clk) sync_in = 1'b1;
    write_setup(2'b01, 1'b0);
    @(negedge clk) setup_wr = 1'b0; sync_in = 1'b0;
    repeat (1000) @(negedge clk);
    setup_wr = 1'b1; setup_mode = 2'b11; setup_ch = 1'b1;
    measure(tr, tc, to, os, gs);
    chk(tr == 4*P + PIPE, "R12 restart ready delay", tr, 4*P + PIPE);
    chk(tc == 3*P, "R12 restart mode clear", tc, 3*P);
    chk(os == 2'b00 && gs == 2'b10, "R12 gain only ch1", {os, gs}, 4'b0010);

    finish_run();
  end
endmodule